// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

This block is a small 8-bit accumulator processor. It runs a narrow set of load and branch instructions from one memory bus. The bus carries a 16-bit address, 8-bit read data, 8-bit write data and a read/write strobe. Every bus access takes one clock cycle, and read data returns combinationally in the same cycle.

After reset the core reads a 16-bit start address from a fixed vector location and places it in the program counter. It then runs a fetch loop. In each pass it reads an opcode and any operand bytes, forms an effective address where the addressing mode needs one, reads the data byte, and updates accumulator A, index register X or the zero flag. The supported forms are inherent, immediate, direct page, extended, zero-offset indexed and PC-relative branch. The program counter, A, X and the effective address register are brought out as debug outputs, together with the zero flag.

Top module: `acc_core`

## Requirements
- R1: While reset is held, PC, A, X, EAR and Z read zero and the bus address is $FFFE. After reset is released the core reads $FFFE, then $FFFF, in consecutive cycles. It takes the byte from $FFFE as the high byte of the PC and the byte from $FFFF as the low byte, and then fetches its first opcode at that PC.
- R2: Opcode $87 clears A and sets Z. It has no operand byte and takes one cycle.
- R3: Opcode $86 loads A with the next byte and takes two cycles.
- R4: Opcode $96 reads one operand byte d, loads A from address $00dd and sets EAR to $00dd. It takes three cycles.
- R5: Opcode $B6 reads two operand bytes, high byte first, forms a 16-bit address, loads A from it and leaves that address in EAR. It takes four cycles.
- R6: Opcode $CE loads X with the two bytes that follow, high byte first. It takes three cycles and does not change A or Z.
- R7: Opcode $A6 copies X into EAR. With postbyte $00 it then loads A from that address, for three cycles in total. With any other postbyte it ends after two cycles, with no data read and with A and Z unchanged.
- R8: Opcode $20 with offset byte r continues at (opcode address + 2 + r), where r is read as two's complement. It takes two cycles. The pair $20,$FE loops on itself.
- R9: Z is 1 after a load or clear of A that leaves A at zero, and 0 after one that leaves A non-zero. This includes values with bit 7 set.
- R10: Any other opcode is a one-cycle no-operation that advances the PC by one.
- R11: The read/write strobe stays at 1 (read) in every cycle, and exactly one bus access is made per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | 16 | Memory address of this cycle's access |
| bus_rdata | input | 8 | Read data, valid in the same cycle |
| bus_wdata | output | 8 | Write data (carries A) |
| bus_rw | output | 1 | 1 = read, 0 = write |
| dbg_pc | output | 16 | Program counter |
| dbg_a | output | 8 | Accumulator A |
| dbg_x | output | 16 | Index register X |
| dbg_ear | output | 16 | Effective address register |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the core with its default parameters: a 16-bit address, an 8-bit data path and the vector at $FFFE. This brings every opcode, both vector bytes and the full sign range of the branch offset into reach. The memory model aliases a 1 KiB array over the whole address space. This lets an extended access at $3800, direct-page data, indexed data and the vector all sit in one small array while still exercising all 16 address bits of the core. For each program the bench counts the cycles to the first fetch of a trailing self-branch, and it checks the debug registers once the core settles in that loop.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rw,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_a,
  output logic [AW-1:0] dbg_x,
  output logic [AW-1:0] dbg_ear,
  output logic          flag_z
);

  localparam int XW = AW - DW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [DW-1:0] OP_CLRA    = 8'h87;
  localparam logic [DW-1:0] OP_LDA_IMM = 8'h86;
  localparam logic [DW-1:0] OP_LDA_DIR = 8'h96;
  localparam logic [DW-1:0] OP_LDA_EXT = 8'hB6;
  localparam logic [DW-1:0] OP_LDA_IDX = 8'hA6;
  localparam logic [DW-1:0] OP_BRA     = 8'h20;
  localparam logic [DW-1:0] OP_LDX_IMM = 8'hCE;

  typedef enum logic [2:0] {S_VHI, S_VLO, S_FETCH, S_OP1, S_OP2, S_DATA} state_t;

  state_t        st;
  logic [AW-1:0] pc, xr, ear;
  logic [DW-1:0] acc, ir;
  logic          zf;

  function automatic logic has_operand(input logic [DW-1:0] op);
    return op == OP_LDA_IMM || op == OP_LDA_DIR || op == OP_LDA_EXT ||
           op == OP_LDA_IDX || op == OP_BRA     || op == OP_LDX_IMM;
  endfunction

  always_comb begin
    case (st)
      S_VHI:   bus_addr = VEC_ADDR;
      S_VLO:   bus_addr = VEC_ADDR + ONE;
      S_DATA:  bus_addr = ear;
      default: bus_addr = pc;
    endcase
  end

  assign bus_rw    = 1'b1;
  assign bus_wdata = acc;
  assign dbg_pc    = pc;
  assign dbg_a     = acc;
  assign dbg_x     = xr;
  assign dbg_ear   = ear;
  assign flag_z    = zf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_VHI;
      pc  <= '0;
      xr  <= '0;
      ear <= '0;
      acc <= '0;
      ir  <= '0;
      zf  <= 1'b0;
    end else begin
      case (st)
        S_VHI: begin
          pc[AW-1 -: DW] <= bus_rdata;
          st <= S_VLO;
        end
        S_VLO: begin
          pc[DW-1:0] <= bus_rdata;
          st <= S_FETCH;
        end
        S_FETCH: begin
          ir <= bus_rdata;
          pc <= pc + ONE;
          if (bus_rdata == OP_CLRA) begin
            acc <= '0;
            zf  <= 1'b1;
          end
          st <= has_operand(bus_rdata) ? S_OP1 : S_FETCH;
        end
        S_OP1: begin
          pc <= pc + ONE;
          st <= S_FETCH;
          case (ir)
            OP_LDA_IMM: begin
              acc <= bus_rdata;
              zf  <= (bus_rdata == '0);
            end
            OP_LDA_DIR: begin
              ear <= {{XW{1'b0}}, bus_rdata};
              st  <= S_DATA;
            end
            OP_LDA_EXT: begin
              ear[AW-1 -: DW] <= bus_rdata;
              st <= S_OP2;
            end
            OP_LDX_IMM: begin
              xr[AW-1 -: DW] <= bus_rdata;
              st <= S_OP2;
            end
            OP_LDA_IDX: begin
              ear <= xr;
              if (bus_rdata == '0) st <= S_DATA;
            end
            OP_BRA: pc <= pc + ONE + {{XW{bus_rdata[DW-1]}}, bus_rdata};
            default: ;
          endcase
        end
        S_OP2: begin
          pc <= pc + ONE;
          if (ir == OP_LDA_EXT) begin
            ear[DW-1:0] <= bus_rdata;
            st <= S_DATA;
          end else begin
            xr[DW-1:0] <= bus_rdata;
            st <= S_FETCH;
          end
        end
        S_DATA: begin
          acc <= bus_rdata;
          zf  <= (bus_rdata == '0);
          st  <= S_FETCH;
        end
        default: st <= S_VHI;
      endcase
    end
  end

  AST_VECTOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_VHI |=> bus_addr == VEC_ADDR + ONE); // R1
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && bus_rdata == OP_CLRA) |=> (st == S_FETCH && acc == '0 && zf)); // R2
  AST_DIRECT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OP1 && ir == OP_LDA_DIR) |=> (st == S_DATA && bus_addr[AW-1:DW] == '0)); // R4
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OP1 && ir == OP_BRA) |=>
      pc == $past(pc) + ONE + {{XW{$past(bus_rdata[DW-1])}}, $past(bus_rdata)}); // R8
  AST_ZERO_TRACKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DATA |=> zf == (acc == '0)); // R9
  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && bus_rdata != OP_CLRA && !has_operand(bus_rdata)) |=>
      (st == S_FETCH && acc == $past(acc) && xr == $past(xr) && pc == $past(pc) + ONE)); // R10

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr, dbg_pc, dbg_x, dbg_ear;
  logic [7:0]  bus_rdata, bus_wdata, dbg_a;
  logic        bus_rw, flag_z;
  logic [7:0]  mem [1024];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  assign bus_rdata = mem[bus_addr[9:0]];

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_rw(bus_rw), .dbg_pc(dbg_pc), .dbg_a(dbg_a),
    .dbg_x(dbg_x), .dbg_ear(dbg_ear), .flag_z(flag_z)
  );

  typedef struct packed {
    logic [47:0] prog;
    logic [3:0]  len;
    logic [7:0]  cycles;
    logic [7:0]  a;
    logic [15:0] x;
    logic        z;
    logic [15:0] ear;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{48'h87_00_00_00_00_00, 4'd1, 8'd3, 8'h00, 16'h0000, 1'b1, 16'h0000},
    '{48'h86_24_00_00_00_00, 4'd2, 8'd4, 8'h24, 16'h0000, 1'b0, 16'h0000},
    '{48'h86_00_00_00_00_00, 4'd2, 8'd4, 8'h00, 16'h0000, 1'b1, 16'h0000},
    '{48'h96_32_00_00_00_00, 4'd2, 8'd5, 8'h57, 16'h0000, 1'b0, 16'h0032},
    '{48'hB6_38_00_00_00_00, 4'd3, 8'd6, 8'hA5, 16'h0000, 1'b0, 16'h3800},
    '{48'hCE_03_91_A6_00_00, 4'd5, 8'd8, 8'h3C, 16'h0391, 1'b0, 16'h0391},
    '{48'hCE_03_90_A6_00_00, 4'd5, 8'd8, 8'h00, 16'h0390, 1'b1, 16'h0390},
    '{48'h01_86_7F_00_00_00, 4'd3, 8'd5, 8'h7F, 16'h0000, 1'b0, 16'h0000},
    '{48'h20_02_86_FF_86_11, 4'd6, 8'd6, 8'h11, 16'h0000, 1'b0, 16'h0000},
    '{48'hCE_03_91_A6_05_00, 4'd5, 8'd7, 8'h00, 16'h0391, 1'b0, 16'h0391},
    '{48'hCE_12_34_00_00_00, 4'd3, 8'd5, 8'h00, 16'h1234, 1'b0, 16'h0000},
    '{48'h86_80_00_00_00_00, 4'd2, 8'd4, 8'h80, 16'h0000, 1'b0, 16'h0000}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R9";   3: return "R4";
      4: return "R5";   5: return "R7";   6: return "R9";   7: return "R10";
      8: return "R8";   9: return "R7";  10: return "R6";  default: return "R3";
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  // 1 KiB memory aliased over 64 KiB; program at $0100, vector bytes at $FFFE/$FFFF
  task automatic load_mem(input logic [15:0] start, input logic [47:0] prog, input int len);
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem[10'h3FE] = start[15:8];
    mem[10'h3FF] = start[7:0];
    mem[10'h032] = 8'h57;
    mem[10'h000] = 8'hA5;
    mem[10'h391] = 8'h3C;
    for (int i = 0; i < len; i++) mem[start[9:0] + 10'(i)] = prog[47 - 8*i -: 8];
    mem[start[9:0] + 10'(len)]     = 8'h20;
    mem[start[9:0] + 10'(len) + 1] = 8'hFE;
  endtask

  // returns the cycle index of the first access to loop_addr, or 99 on timeout
  task automatic run_to(input logic [15:0] loop_addr, output int k, output logic rw_ok);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    rw_ok = 1'b1;
    while (bus_addr != loop_addr && k < 99) begin
      if (bus_rw !== 1'b1) rw_ok = 1'b0;
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int   k;
    logic rw_ok;
    logic [15:0] loop_addr;

    // directed: reset state and vector sequence (R1)
    load_mem(16'h0200, 48'h87_00_00_00_00_00, 1);
    repeat (3) @(negedge clk);
    chk(dbg_pc == 16'h0 && dbg_a == 8'h0 && dbg_x == 16'h0 && dbg_ear == 16'h0 && !flag_z,
        "R1", "registers in reset", {dbg_pc, dbg_a, 7'b0, flag_z}, 0);
    chk(bus_addr == 16'hFFFE, "R1", "address in reset", bus_addr, 16'hFFFE);
    @(negedge clk);
    rst_n = 1'b1;
    chk(bus_addr == 16'hFFFE, "R1", "first vector read", bus_addr, 16'hFFFE);
    @(negedge clk);
    chk(bus_addr == 16'hFFFF, "R1", "second vector read", bus_addr, 16'hFFFF);
    @(negedge clk);
    chk(bus_addr == 16'h0200 && dbg_pc == 16'h0200, "R1", "first fetch at vector",
        bus_addr, 16'h0200);
    @(negedge clk);
    chk(bus_addr == 16'h0201 && dbg_a == 8'h00 && flag_z, "R2", "clear then loop fetch",
        bus_addr, 16'h0201);
    rst_n = 1'b0;

    // table of programs, each followed by a branch to itself
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      rst_n = 1'b0;
      load_mem(16'h0100, VEC[v].prog, int'(VEC[v].len));
      loop_addr = 16'h0100 + 16'(VEC[v].len);
      run_to(loop_addr, k, rw_ok);
      chk(k == int'(VEC[v].cycles), tag_of(v), "cycles to loop", k, VEC[v].cycles);
      chk(dbg_pc == loop_addr, "R8", "PC at loop fetch", dbg_pc, loop_addr);
      chk(rw_ok, "R11", "read strobe held", rw_ok, 1);
      repeat (11) @(negedge clk);
      chk(dbg_a == VEC[v].a, tag_of(v), "A", dbg_a, VEC[v].a);
      chk(dbg_x == VEC[v].x, tag_of(v), "X", dbg_x, VEC[v].x);
      chk(flag_z == VEC[v].z, "R9", "Z", flag_z, VEC[v].z);
      chk(dbg_ear == VEC[v].ear, tag_of(v), "EAR", dbg_ear, VEC[v].ear);
      chk(dbg_pc == loop_addr || dbg_pc == loop_addr + 16'd1, "R8", "self loop holds",
          dbg_pc, loop_addr);
      chk(bus_rw == 1'b1, "R11", "read strobe in loop", bus_rw, 1);
    end

    // directed: backward branch of -4 re-runs the immediate load (R8)
    @(negedge clk);
    rst_n = 1'b0;
    load_mem(16'h0100, 48'h86_05_20_FC_00_00, 4);
    run_to(16'h0100, k, rw_ok);
    repeat (4) @(negedge clk);
    chk(bus_addr == 16'h0100 && dbg_a == 8'h05, "R8", "backward target",
        bus_addr, 16'h0100);

    finish_run();
  end

endmodule